// File: doc/BRIEF.md
# Debug Break Pulse Output Controller

This block turns a breakpoint-match strobe into an active-low pulse on an external break indication pin. Board-level equipment such as a logic analyser or a second device can use this pulse as a trigger. Two responses are available, and a mode input selects one of them when a match occurs.

In the first response, the break pulse is emitted alongside a one-cycle request that starts the debug monitor. The pin stays low until the monitor reports that it has been entered, or until a 77-cycle ceiling expires, whichever comes first.

In the second response, the pin is the only reaction to the match. It is held low for exactly 4 cycles, which is the fastest possible response. The core is held suspended for exactly those cycles.

A separate enable input gates whether the pin is ever driven. In the monitor response, the monitor-start request still issues when the pin is disabled. Breakpoint matches arrive as single-cycle strobes. A match that arrives while a pulse is running is ignored.

Top module: `brk_pin_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving reset, `brk_pin_no` is high and both `mon_start_o` and `core_susp_o` are low.
- R2: With `sole_mode_i`=1 and `pin_en_i`=1, a match drives `brk_pin_no` low for exactly 4 consecutive cycles. The pulse starts in the cycle after the match. `mon_start_o` stays low throughout.
- R3: `core_susp_o` is high in exactly the cycles in which a sole-mode pulse holds the pin low. It is never high during a monitor-mode pulse.
- R4: With `sole_mode_i`=0, a match raises `mon_start_o` for exactly one cycle, the cycle after the match. This happens whatever the value of `pin_en_i`.
- R5: With `sole_mode_i`=0 and `pin_en_i`=1, a match drives `brk_pin_no` low from the cycle after the match. If no acknowledge arrives, the pin stays low for 77 cycles.
- R6: In a monitor-mode pulse, `mon_ack_i` high at a clock edge ends the pulse, and the pin is high from the next cycle. The acknowledge has no effect on a sole-mode pulse or when the block is idle.
- R7: With `pin_en_i`=0, `brk_pin_no` stays high in both modes. In sole mode a disabled match produces no output change at all.
- R8: A match that arrives while a pulse is running is ignored. It neither restarts nor lengthens the pulse, and it issues no extra `mon_start_o`.
- R9: The mode and the enable are taken at the match. Changing them during a pulse does not change its length or its suspend behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bp_match_i | input | 1 | Single-cycle breakpoint-match strobe |
| pin_en_i | input | 1 | 1 allows the break pin to be driven |
| sole_mode_i | input | 1 | 1: pin is the only response (4-cycle pulse, core suspended); 0: pin accompanies a monitor start |
| mon_ack_i | input | 1 | Monitor has been entered; ends a monitor-mode pulse |
| brk_pin_no | output | 1 | Active-low break indication pin |
| mon_start_o | output | 1 | One-cycle monitor-start request |
| core_susp_o | output | 1 | Core-suspend request, high while a sole-mode pulse runs |

## Verification
The hardest situations to reach from the ports are events that collide with a pulse already in flight. One case is a second match in the middle of a pulse. The other is a mode or enable flip partway through, where the pulse must keep the settings taken at its start. The bench starts a pulse and then, at a chosen cycle index inside it, injects the extra match or the configuration change. It then counts the low cycles, the suspend cycles and the monitor-start pulses over a window longer than the 77-cycle ceiling. The acknowledge is placed at the first cycle, at a middle cycle and at the last cycle of the window, which covers both ways a monitor pulse can end.

// File: rtl/brk_pin_pkg.sv
package brk_pin_pkg;
    localparam int unsigned SOLE_LEN_DEF = 4;
    localparam int unsigned MON_MAX_DEF  = 77;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_SOLE     = 2'd1,
        ACT_MON_PIN  = 2'd2,
        ACT_MON_ONLY = 2'd3
    } brk_act_e;
endpackage

// File: rtl/brk_act_decode.sv
module brk_act_decode
    import brk_pin_pkg::*;
(
    input  logic     match_i,
    input  logic     pin_en_i,
    input  logic     sole_i,
    input  logic     busy_i,
    output brk_act_e act_o
);
    always_comb begin
        act_o = ACT_NONE;
        if (match_i && !busy_i) begin
            if (sole_i) begin
                act_o = pin_en_i ? ACT_SOLE : ACT_NONE;
            end else begin
                act_o = pin_en_i ? ACT_MON_PIN : ACT_MON_ONLY;
            end
        end
    end
endmodule

// File: rtl/brk_pulse_timer.sv
module brk_pulse_timer #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             abort_i,
    output logic             active_o
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!t_q.active) begin
            if (start_i) begin
                t_d.active = 1'b1;
                t_d.cnt    = load_i;
            end
        end else if (abort_i || (t_q.cnt == '0)) begin
            t_d.active = 1'b0;
            t_d.cnt    = '0;
        end else begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign active_o = t_q.active;

    AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !t_q.active); // R8
endmodule

// File: rtl/brk_pin_ctrl.sv
module brk_pin_ctrl
    import brk_pin_pkg::*;
#(
    parameter int unsigned SOLE_LEN = SOLE_LEN_DEF,
    parameter int unsigned MON_MAX  = MON_MAX_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bp_match_i,
    input  logic pin_en_i,
    input  logic sole_mode_i,
    input  logic mon_ack_i,
    output logic brk_pin_no,
    output logic mon_start_o,
    output logic core_susp_o
);
    localparam int unsigned MAX_LEN = (SOLE_LEN > MON_MAX) ? SOLE_LEN : MON_MAX;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] SOLE_LOAD = CNT_W'(SOLE_LEN - 1);
    localparam logic [CNT_W-1:0] MON_LOAD  = CNT_W'(MON_MAX - 1);

    typedef struct packed {
        logic sole;
        logic mon_pls;
    } ctl_t;

    ctl_t     c_d, c_q;
    brk_act_e act;
    logic     active;
    logic     start;
    logic     abort;
    logic [CNT_W-1:0] load;

    brk_act_decode u_dec (
        .match_i  (bp_match_i),
        .pin_en_i (pin_en_i),
        .sole_i   (sole_mode_i),
        .busy_i   (active),
        .act_o    (act)
    );

    always_comb begin
        c_d         = c_q;
        start       = (act == ACT_SOLE) || (act == ACT_MON_PIN);
        load        = (act == ACT_SOLE) ? SOLE_LOAD : MON_LOAD;
        abort       = mon_ack_i && !c_q.sole;
        c_d.mon_pls = (act == ACT_MON_PIN) || (act == ACT_MON_ONLY);
        if (start) begin
            c_d.sole = (act == ACT_SOLE);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    brk_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .load_i   (load),
        .abort_i  (abort),
        .active_o (active)
    );

    assign brk_pin_no  = ~active;
    assign core_susp_o = active && c_q.sole;
    assign mon_start_o = c_q.mon_pls;

    AST_SUSP_WITH_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_susp_o |-> !brk_pin_no); // R3
    AST_SOLE_NO_MON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_susp_o |-> !mon_start_o); // R2
    AST_MON_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mon_start_o |=> !mon_start_o); // R4
    AST_ACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!brk_pin_no && !core_susp_o && mon_ack_i) |=> brk_pin_no); // R6
    AST_SOLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bp_match_i && sole_mode_i && !pin_en_i && brk_pin_no)
        |=> (brk_pin_no && !mon_start_o && !core_susp_o)); // R7
endmodule

// File: tb/brk_pin_ctrl_bench.sv
module brk_pin_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic match = 1'b0, en = 1'b0, sole = 1'b0, ack = 1'b0;
    logic pin_n, mon, susp;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    brk_pin_ctrl u_brk_pin_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .bp_match_i(match), .pin_en_i(en),
        .sole_mode_i(sole), .mon_ack_i(ack), .brk_pin_no(pin_n),
        .mon_start_o(mon), .core_susp_o(susp)
    );

    typedef struct packed {
        logic       v_sole;
        logic       v_en;
        logic [7:0] v_ack;
        logic [7:0] v_len;
        logic [7:0] v_susp;
        logic [7:0] v_mon;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 8'd0,  8'd4,  8'd4, 8'd1 - 8'd1},
        '{1'b0, 1'b1, 8'd0,  8'd77, 8'd0, 8'd1},
        '{1'b0, 1'b1, 8'd10, 8'd10, 8'd0, 8'd1},
        '{1'b0, 1'b0, 8'd0,  8'd0,  8'd0, 8'd1},
        '{1'b1, 1'b0, 8'd0,  8'd0,  8'd0, 8'd0},
        '{1'b0, 1'b1, 8'd1,  8'd1,  8'd0, 8'd1},
        '{1'b0, 1'b1, 8'd77, 8'd77, 8'd0, 8'd1},
        '{1'b1, 1'b1, 8'd2,  8'd4,  8'd4, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One match, then a 90-cycle observation window sampled on falling edges.
    task automatic run(input logic s, input logic e, input int ack_at,
                       input int retrig_at, input bit flip,
                       input int exp_len, input int exp_susp, input int exp_mon,
                       input string req);
        int low = 0, sus = 0, mons = 0, first_hi = -1, mon_at0 = 0;
        @(negedge clk);
        sole = s; en = e; match = 1'b1;
        @(negedge clk);
        match = 1'b0;
        for (int i = 0; i < 90; i++) begin
            if (!pin_n) low++;
            else if (first_hi < 0) first_hi = i;
            if (susp) sus++;
            if (mon) mons++;
            if (i == 0) mon_at0 = mon;
            ack   = (ack_at > 0 && i == ack_at - 1);
            match = (retrig_at >= 0 && i == retrig_at);
            if (flip && i == 1) begin sole = ~s; en = ~e; end
            @(negedge clk);
        end
        ack = 1'b0; match = 1'b0;
        check({req, " low cycles"}, low, exp_len);
        check({req, " contiguous from first cycle"}, first_hi, exp_len);
        check({req, " suspend cycles"}, sus, exp_susp);
        check({req, " monitor starts"}, mons, exp_mon);
        if (exp_mon > 0) check({req, " monitor start timing"}, mon_at0, 1);
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 pin in reset", pin_n, 1);
        check("R1 mon in reset", mon, 0);
        check("R1 susp in reset", susp, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin after reset", pin_n, 1);

        // Table: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 8; k++) begin
            run(VECS[k].v_sole, VECS[k].v_en, int'(VECS[k].v_ack), -1, 1'b0,
                int'(VECS[k].v_len), int'(VECS[k].v_susp), int'(VECS[k].v_mon),
                $sformatf("R2/R5/R6/R7 vec%0d", k));
        end

        // R6: acknowledge while idle has no effect
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R6 idle ack pin", pin_n, 1);
        check("R6 idle ack mon", mon, 0);

        // R8: retrigger during pulses
        run(1'b0, 1'b1, 0, 5, 1'b0, 77, 0, 1, "R8 monitor retrigger");
        run(1'b1, 1'b1, 0, 1, 1'b0, 4, 4, 0, "R8 sole retrigger");

        // R9: configuration flips mid-pulse
        run(1'b1, 1'b1, 0, -1, 1'b1, 4, 4, 0, "R9 sole flip");
        run(1'b0, 1'b1, 0, -1, 1'b1, 77, 0, 1, "R9 monitor flip");

        // R1: reset in the middle of a pulse
        @(negedge clk); sole = 1'b0; en = 1'b1; match = 1'b1;
        @(negedge clk); match = 1'b0;
        check("R5 pin low before reset", pin_n, 0);
        rst_n = 1'b0;
        #1;
        check("R1 pin on mid-pulse reset", pin_n, 1);
        check("R3 susp on mid-pulse reset", susp, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule